// File: doc/BRIEF.md
# Receive PHY Bring-Up Sequencer

This block brings a receive D-PHY from reset into normal operation without software help. A one-cycle start request carries a lane count and a 6-bit frequency-range code. The block captures both, then works through a fixed order of control-field updates. It releases the forced receive and forced stop modes, drops the turnaround request, disables turnaround on every lane, and enables the requested lanes.

After those updates it raises the test clock and holds the test-clear line for a timed interval. A second interval of the same length follows once the line is released. The block then programs the PHY through its edge-ordered test port. Each write sends an 8-bit test code followed by an 8-bit data byte, and the writes come from a fixed table into which the range code is inserted.

Every step lasts a number of system clocks that is captured at start, so the PHY always sees clean setup and hold. The test-clear intervals come from a cycle count derived from the clock frequency. A busy flag covers the whole sequence, and a one-cycle done pulse ends it. A separate power-off input clears the lane enables whenever it is applied.

Top module: `phy_rx_bringup_seq`

## Requirements
- R1: After reset, force_rx_o, force_stop_o and turn_req_o are 4'hF; turn_dis_o and lane_en_o are 0; test_clk_o, test_clr_o, test_en_o, test_din_o, busy_o and done_o are 0.
- R2: A start_i sampled while idle begins the sequence. On the next cycle busy_o is high and force_rx_o is 0. The fields then change one step at a time, each step held for H cycles, in this order: force_rx_o to 0, force_stop_o to 0, turn_req_o to 0, turn_dis_o to 4'hF, lane_en_o to the lane mask, test_clk_o to 1. H is step_hold_i, with 0 treated as 1.
- R3: The lane mask sets bit i for every i below the lane count. A count of 4 or more gives 4'hF, and a count of 0 gives 4'h0.
- R4: test_clr_o is high for exactly WAIT_CYC cycles, followed by WAIT_CYC cycles with every output unchanged. WAIT_CYC = (CLK_HZ/1,000,000)·WAIT_US. test_clr_o is high only while test_clk_o is high.
- R5: Each test write has five phases of H cycles each. First test_din_o carries the code and test_en_o goes to 1. Then test_clk_o goes to 0, then test_en_o goes to 0, then test_din_o carries the data, and finally test_clk_o goes to 1.
- R6: The seven writes, as code/data pairs, are 8'h34/8'h00, 8'h44, 8'h54, 8'h84 and 8'h94 each with data {1'b0, range, 1'b0} (the range code shifted left by one), 8'h75/8'h04, and finally 8'h00/8'h00.
- R7: done_o is high for one cycle, H cycles after the last write's clock rise. busy_o is high from the cycle after start through the done cycle and low on the cycle after.
- R8: A start_i that arrives while busy_o is high has no effect on the sequence or its outputs.
- R9: power_off_i clears lane_en_o on the next cycle and touches no other output. It takes priority over the lane-enable step and does not stop the sequence.
- R10: Lane count, range code and step hold are taken only at start. Changing those inputs later does not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| lanes_i | input | 3 | Requested lane count |
| range_i | input | 6 | Frequency-range code |
| step_hold_i | input | 8 | System clocks per step (0 acts as 1) |
| power_off_i | input | 1 | Clear lane enables |
| force_rx_o | output | 4 | Forced receive mode per lane |
| force_stop_o | output | 4 | Forced stop mode per lane |
| turn_req_o | output | 4 | Turnaround request per lane |
| turn_dis_o | output | 4 | Turnaround disable per lane |
| lane_en_o | output | 4 | Lane enables |
| test_clk_o | output | 1 | Test port clock |
| test_clr_o | output | 1 | Test port clear |
| test_en_o | output | 1 | Test port enable (code phase) |
| test_din_o | output | 8 | Test port code/data byte |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every output is a register. A start sampled at an edge therefore shows its first step one cycle later. Each later step takes its own dwell (H cycles for ordinary steps, WAIT_CYC for each test-clear interval), and done follows H cycles after the last clock rise. The bench builds the expected value of every output for every cycle of the sequence from this schedule and samples on the falling clock edge, half a cycle after the register changes. Power-off, late start requests and input changes are applied on a falling edge and checked on the next one, so a single rising edge separates cause and effect.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

  localparam int RANGE_W  = 6;
  localparam int TBYTE_W  = 8;
  localparam int TW_COUNT = 7;
  localparam int TW_IDX_W = 3;
  localparam logic [TW_IDX_W-1:0] TW_LAST = TW_IDX_W'(TW_COUNT - 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FRX,
    ST_FSTOP,
    ST_TREQ,
    ST_TDIS,
    ST_LANE,
    ST_TCLK,
    ST_CLR_ON,
    ST_CLR_OFF,
    ST_W_CODE,
    ST_W_CLKLO,
    ST_W_ENLO,
    ST_W_DATA,
    ST_W_CLKHI,
    ST_DONE
  } seq_state_e;

  // Test code for write slot idx; the slot order is part of the behaviour.
  function automatic logic [TBYTE_W-1:0] slot_code(input logic [TW_IDX_W-1:0] idx);
    case (idx)
      3'd0:    slot_code = 8'h34;
      3'd1:    slot_code = 8'h44;
      3'd2:    slot_code = 8'h54;
      3'd3:    slot_code = 8'h84;
      3'd4:    slot_code = 8'h94;
      3'd5:    slot_code = 8'h75;
      default: slot_code = 8'h00;
    endcase
  endfunction

  // Data byte for write slot idx; the lane slots carry the range code doubled.
  function automatic logic [TBYTE_W-1:0] slot_data(input logic [TW_IDX_W-1:0] idx,
                                                   input logic [RANGE_W-1:0] rng);
    case (idx)
      3'd1, 3'd2, 3'd3, 3'd4: slot_data = {1'b0, rng, 1'b0};
      3'd5:                   slot_data = 8'h04;
      default:                slot_data = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/seq_dwell_timer.sv
module seq_dwell_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expired_o = (cnt_q == '0);

  // A dwell of zero would wrap the counter: every step lasts at least one cycle.
  assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (len_i != '0));

endmodule

// File: rtl/seq_write_table.sv
module seq_write_table
  import phy_bringup_pkg::*;
(
  input  logic [TW_IDX_W-1:0] idx_i,
  input  logic [RANGE_W-1:0]  range_i,
  output logic [TBYTE_W-1:0]  code_o,
  output logic [TBYTE_W-1:0]  data_o
);

  always_comb begin
    code_o = slot_code(idx_i);
    data_o = slot_data(idx_i, range_i);
  end

endmodule

// File: rtl/phy_rx_bringup_seq.sv
module phy_rx_bringup_seq
  import phy_bringup_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CLK_HZ    = 125_000_000,
  parameter int WAIT_US   = 120,
  parameter int HOLD_W    = 8,
  localparam int LCNT_W   = $clog2(NUM_LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [LCNT_W-1:0]    lanes_i,
  input  logic [RANGE_W-1:0]   range_i,
  input  logic [HOLD_W-1:0]    step_hold_i,
  input  logic                 power_off_i,
  output logic [NUM_LANES-1:0] force_rx_o,
  output logic [NUM_LANES-1:0] force_stop_o,
  output logic [NUM_LANES-1:0] turn_req_o,
  output logic [NUM_LANES-1:0] turn_dis_o,
  output logic [NUM_LANES-1:0] lane_en_o,
  output logic                 test_clk_o,
  output logic                 test_clr_o,
  output logic                 test_en_o,
  output logic [TBYTE_W-1:0]   test_din_o,
  output logic                 busy_o,
  output logic                 done_o
);

  localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * WAIT_US;
  localparam int WAIT_W   = $clog2(WAIT_CYC + 1);
  localparam int CNT_W    = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;

  function automatic logic [NUM_LANES-1:0] lane_mask(input logic [LCNT_W-1:0] n);
    for (int i = 0; i < NUM_LANES; i++) begin
      lane_mask[i] = (i < int'(n));
    end
  endfunction

  seq_state_e           state_q, nxt_state;
  logic [TW_IDX_W-1:0]  wr_idx_q, nxt_idx;
  logic [LCNT_W-1:0]    lanes_q;
  logic [RANGE_W-1:0]   range_q;
  logic [HOLD_W-1:0]    hold_q, hold_src;
  logic [CNT_W-1:0]     hold_len, dwell_len;
  logic [TBYTE_W-1:0]   wr_code, wr_data;

  // Named internal events.
  logic seq_launch, step_adv, step_go, wr_last, tmr_expired;

  assign seq_launch = (state_q == ST_IDLE) && start_i;
  assign step_adv   = (state_q != ST_IDLE) && tmr_expired;
  assign step_go    = seq_launch || step_adv;
  assign wr_last    = (wr_idx_q == TW_LAST);

  // The first step is entered on the launch edge, before hold_q is captured.
  assign hold_src = (state_q == ST_IDLE) ? step_hold_i : hold_q;
  assign hold_len = (hold_src == '0) ? CNT_W'(1) : CNT_W'(hold_src);

  always_comb begin
    unique case (state_q)
      ST_IDLE:    nxt_state = ST_FRX;
      ST_FRX:     nxt_state = ST_FSTOP;
      ST_FSTOP:   nxt_state = ST_TREQ;
      ST_TREQ:    nxt_state = ST_TDIS;
      ST_TDIS:    nxt_state = ST_LANE;
      ST_LANE:    nxt_state = ST_TCLK;
      ST_TCLK:    nxt_state = ST_CLR_ON;
      ST_CLR_ON:  nxt_state = ST_CLR_OFF;
      ST_CLR_OFF: nxt_state = ST_W_CODE;
      ST_W_CODE:  nxt_state = ST_W_CLKLO;
      ST_W_CLKLO: nxt_state = ST_W_ENLO;
      ST_W_ENLO:  nxt_state = ST_W_DATA;
      ST_W_DATA:  nxt_state = ST_W_CLKHI;
      ST_W_CLKHI: nxt_state = wr_last ? ST_DONE : ST_W_CODE;
      ST_DONE:    nxt_state = ST_IDLE;
      default:    nxt_state = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (nxt_state)
      ST_CLR_ON, ST_CLR_OFF: dwell_len = CNT_W'(WAIT_CYC);
      ST_DONE:               dwell_len = CNT_W'(1);
      default:               dwell_len = hold_len;
    endcase
  end

  // The table is addressed with the slot the next step will use.
  assign nxt_idx = (state_q == ST_W_CLKHI) ? (wr_idx_q + TW_IDX_W'(1)) : wr_idx_q;

  seq_write_table u_table (
    .idx_i   (nxt_idx),
    .range_i (range_q),
    .code_o  (wr_code),
    .data_o  (wr_data)
  );

  seq_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (step_go),
    .len_i     (dwell_len),
    .expired_o (tmr_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      wr_idx_q     <= '0;
      lanes_q      <= '0;
      range_q      <= '0;
      hold_q       <= '0;
      force_rx_o   <= '1;
      force_stop_o <= '1;
      turn_req_o   <= '1;
      turn_dis_o   <= '0;
      lane_en_o    <= '0;
      test_clk_o   <= 1'b0;
      test_clr_o   <= 1'b0;
      test_en_o    <= 1'b0;
      test_din_o   <= '0;
    end else begin
      if (step_go) begin
        state_q <= nxt_state;
        if (state_q == ST_W_CLKHI) wr_idx_q <= nxt_idx;
        unique case (nxt_state)
          ST_FRX: begin
            force_rx_o <= '0;
            lanes_q    <= lanes_i;
            range_q    <= range_i;
            hold_q     <= step_hold_i;
            wr_idx_q   <= '0;
          end
          ST_FSTOP:   force_stop_o <= '0;
          ST_TREQ:    turn_req_o   <= '0;
          ST_TDIS:    turn_dis_o   <= '1;
          ST_LANE:    lane_en_o    <= lane_mask(lanes_q);
          ST_TCLK:    test_clk_o   <= 1'b1;
          ST_CLR_ON:  test_clr_o   <= 1'b1;
          ST_CLR_OFF: test_clr_o   <= 1'b0;
          ST_W_CODE: begin
            test_din_o <= wr_code;
            test_en_o  <= 1'b1;
          end
          ST_W_CLKLO: test_clk_o <= 1'b0;
          ST_W_ENLO:  test_en_o  <= 1'b0;
          ST_W_DATA:  test_din_o <= wr_data;
          ST_W_CLKHI: test_clk_o <= 1'b1;
          default: ;
        endcase
      end
      // Power-off wins over the lane-enable step.
      if (power_off_i) lane_en_o <= '0;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  // ---------------- assertions ----------------
  logic [CNT_W:0] clr_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          clr_run_q <= '0;
    else if (test_clr_o) clr_run_q <= clr_run_q + (CNT_W+1)'(1);
    else                 clr_run_q <= '0;
  end

  assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_launch |=> (busy_o && force_rx_o == '0));

  assert_clr_under_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    test_clr_o |-> test_clk_o);

  assert_clr_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_clr_o) |-> (clr_run_q == (CNT_W+1)'(WAIT_CYC)));

  assert_clk_fall_en_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_clk_o) |-> test_en_o);

  assert_en_rise_clk_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_en_o) |-> test_clk_o);

  assert_en_fall_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_en_o) |-> !test_clk_o);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(range_q) && $stable(lanes_q) && $stable(hold_q)));

  assert_poff_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    power_off_i |=> (lane_en_o == '0));

endmodule

// File: tb/phy_rx_bringup_seq_tb_top.sv
module phy_rx_bringup_seq_tb_top;

  localparam int NL    = 4;
  localparam int CLKHZ = 2_000_000;
  localparam int WUS   = 100;
  localparam int HW    = 8;
  localparam int WAITC = (CLKHZ / 1_000_000) * WUS;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start_i, power_off_i;
  logic [2:0]    lanes_i;
  logic [5:0]    range_i;
  logic [HW-1:0] step_hold_i;
  logic [NL-1:0] force_rx_o, force_stop_o, turn_req_o, turn_dis_o, lane_en_o;
  logic          test_clk_o, test_clr_o, test_en_o, busy_o, done_o;
  logic [7:0]    test_din_o;

  phy_rx_bringup_seq #(.NUM_LANES(NL), .CLK_HZ(CLKHZ), .WAIT_US(WUS), .HOLD_W(HW)) dut_i (
    .clk, .rst_n, .start_i, .lanes_i, .range_i, .step_hold_i, .power_off_i,
    .force_rx_o, .force_stop_o, .turn_req_o, .turn_dis_o, .lane_en_o,
    .test_clk_o, .test_clr_o, .test_en_o, .test_din_o, .busy_o, .done_o
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int inj_at = -1;

  logic [NL-1:0] e_frx, e_fstop, e_treq, e_tdis, e_len;
  logic          e_tclk, e_tclr, e_ten, e_busy, e_done;
  logic [7:0]    e_din;

  function automatic logic [NL-1:0] exp_mask(input int n);
    logic [NL-1:0] m = '0;
    for (int i = 0; i < n && i < NL; i++) m = {m[NL-2:0], 1'b1};
    return m;
  endfunction

  function automatic logic [7:0] exp_code(input int k);
    logic [7:0] codes [7] = '{8'h34, 8'h44, 8'h54, 8'h84, 8'h94, 8'h75, 8'h00};
    return codes[k];
  endfunction

  function automatic logic [7:0] exp_data(input int k, input logic [5:0] r);
    if (k >= 1 && k <= 4) return 8'(r) * 8'd2;
    if (k == 5) return 8'h04;
    return 8'h00;
  endfunction

  task automatic compare(input string tag);
    logic [36:0] got, exp;
    got = {force_rx_o, force_stop_o, turn_req_o, turn_dis_o, lane_en_o,
           test_clk_o, test_clr_o, test_en_o, test_din_o, busy_o, done_o};
    exp = {e_frx, e_fstop, e_treq, e_tdis, e_len,
           e_tclk, e_tclr, e_ten, e_din, e_busy, e_done};
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, got, exp);
    end
  endtask

  // Sample n falling edges; drive late-start stimulus between samples.
  task automatic hold(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(tag);
      cyc++;
      power_off_i = 1'b0;
      start_i = (cyc == inj_at);
      if (cyc == inj_at || cyc == inj_at + 3) begin
        // R8 / R10: new start and new inputs while busy must change nothing
        lanes_i     = 3'($urandom_range(0, 7));
        range_i     = 6'($urandom);
        step_hold_i = HW'($urandom_range(1, 9));
      end
    end
  endtask

  task automatic run_seq(input int lanes, input logic [5:0] rng, input int hl,
                         input int inj, input bit poff);
    int h;
    h = (hl == 0) ? 1 : hl;
    @(negedge clk);
    lanes_i = 3'(lanes); range_i = rng; step_hold_i = HW'(hl); start_i = 1'b1;
    cyc = 0; inj_at = inj;
    e_busy = 1'b1;
    e_frx = '0;   hold(h, "R2 force-rx clear");
    e_fstop = '0; hold(h, "R2 force-stop clear");
    e_treq = '0;  hold(h, "R2 turn-request clear");
    e_tdis = '1;  hold(h, "R2 turn-disable set");
    e_len = exp_mask(lanes);
    if (poff) begin
      hold(1, "R3 lane mask");
      power_off_i = 1'b1; e_len = '0;
      hold(h - 1, "R9 power-off during lane step");
    end else begin
      hold(h, "R3 lane mask");
    end
    e_tclk = 1'b1; hold(h, "R2 test clock high");
    e_tclr = 1'b1; hold(WAITC, "R4 clear asserted");
    e_tclr = 1'b0; hold(WAITC, "R4 clear released wait");
    for (int k = 0; k < 7; k++) begin
      e_din = exp_code(k); e_ten = 1'b1; hold(h, "R6 code phase");
      e_tclk = 1'b0;                     hold(h, "R5 clock low");
      e_ten = 1'b0;                      hold(h, "R5 enable low");
      e_din = exp_data(k, rng);          hold(h, "R6 data phase");
      e_tclk = 1'b1;                     hold(h, "R5 clock high");
    end
    e_done = 1'b1; hold(1, "R7 done pulse");
    e_done = 1'b0; e_busy = 1'b0; hold(1, "R7 idle after done");
    inj_at = -1;
  endtask

  initial begin
    #(8 * 150_000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start_i = 1'b0; power_off_i = 1'b0;
    lanes_i = '0; range_i = '0; step_hold_i = '0;
    e_frx = '1; e_fstop = '1; e_treq = '1; e_tdis = '0; e_len = '0;
    e_tclk = 1'b0; e_tclr = 1'b0; e_ten = 1'b0; e_din = '0; e_busy = 1'b0; e_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hold(2, "R1 reset state");

    // Directed corners
    run_seq(4, 6'h3C, 0, -1, 1'b0);   // R3 full mask, R2 hold of zero acts as one
    run_seq(1, 6'h22, 3, 10, 1'b0);   // R8 / R10 late start and input changes
    run_seq(2, 6'h15, 2, -1, 1'b1);   // R9 power-off wins over lane step
    run_seq(0, 6'h01, 1, -1, 1'b0);   // R3 zero lanes
    run_seq(7, 6'h3F, 2, 40, 1'b0);   // R3 saturating count, R8 start while busy

    // R9 power-off while idle touches only the lane enables
    @(negedge clk);
    power_off_i = 1'b1; e_len = '0;
    hold(1, "R9 idle power-off");
    hold(2, "R9 no other effect");

    // Random sequences
    for (int s = 0; s < 4; s++) begin
      run_seq($urandom_range(1, 4), 6'($urandom), $urandom_range(0, 5),
              (s % 2 == 0) ? int'($urandom_range(2, 30)) : -1, 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule